// File: doc/BRIEF.md
# External Interrupt Line Controller

This block gathers up to 32 asynchronous interrupt request pins and turns them into one maskable interrupt toward the processor. It also provides a separate non-maskable request. Every pin first passes through a two-flop synchroniser. Software then chooses, pin by pin, whether the pin is sensed by level or by edge, and which polarity or direction counts as active. Detected requests are recorded in a status register. They are gated by a per-pin enable mask, and the combined result drives `irq_out`.

Software reaches the block through a plain 32-bit write strobe and a combinational read port, addressed by byte offset. The enable mask and the status flags are never written directly. Dedicated strobe offsets set or clear individual bits, so a handler can change one pin without a read-modify-write. The parameter `NUM_LINES` sets how many pins exist. Bits above that count cannot be written and always read as zero, so software can count the pins by writing ones to the sense-select register and reading the value back.

Top module: `extint_ctrl`

## Requirements
- R1: After reset, every readable offset returns 0, and `irq_out` and `nmi_out` are low. All pins start in edge mode with falling-edge selection.
- R2: Writing to offset 0x00 sets each mask bit whose data bit is 1. Writing to offset 0x04 clears each mask bit whose data bit is 1. Data bits that are 0 leave the mask unchanged. Offset 0x08 reads the mask.
- R3: A pin whose mode bit (offset 0x14) is 0 is edge sensed. Edge bit (offset 0x18) = 1 selects a rising edge, and 0 selects a falling edge. A detected edge sets the pin's status bit (offset 0x0C) on the third rising clock edge after the pin changes. The bit then stays set after the pin returns to idle.
- R4: Writing a 1 to a bit at offset 0x10 clears that pin's latched edge status. Data bits that are 0 have no effect. If a new edge is detected in the same cycle as the clear, the status bit stays set.
- R5: A pin whose mode bit is 1 is level sensed. Level bit (offset 0x1C) = 1 means active-high, and 0 means active-low. Its status bit follows the active condition with the same three-edge latency, so a clear write has no lasting effect while the level is still active.
- R6: `irq_out` is high exactly when some pin has both its status bit and its mask bit set.
- R7: Bit 0 of offset 0x24 is the non-maskable enable, and it reads back in bit 0. `nmi_out` is high when that enable is set and pin 0's status bit is set, whatever the mask holds.
- R8: Bits at or above `NUM_LINES` in the mode, edge, level, mask and status registers read as 0. Writing all ones to offset 0x14 reads back as 2^NUM_LINES-1.
- R9: The write-only offsets (0x00, 0x04, 0x10) and all undefined offsets read as 0. Writes to undefined offsets change no state.
- R10: With all mode bits 1 and the edge and level registers 0, every pin is triggered by a low level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_in | input | NUM_LINES | Asynchronous external request pins |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_out | output | 1 | Combined maskable interrupt request |
| nmi_out | output | 1 | Non-maskable request driven from pin 0 |

## Verification
The hardest case to reach is a clear write that lands in exactly the cycle in which a fresh edge is detected on the same pin. The bench counts the two synchroniser stages and the edge register from a pin change made on a falling clock edge. It then places the clear strobe so that it is sampled on the same rising edge that records the new event. The remaining cases come from a sweep of every pin against every trigger kind. In each run a single pin is moved while its neighbours stay idle, and the sweep checks the status value one cycle before and at the expected latency.

// File: rtl/extint_pkg.sv
// Shared constants for the external interrupt controller.
// Assumes byte offsets on an 8-bit address and a 32-bit data path.
package extint_pkg;
    parameter int ADDR_W = 8;
    parameter int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFF_MASK_SET = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_MASK_CLR = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_MASK_RD  = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_STATUS   = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_STAT_CLR = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_SENSE    = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_DIR      = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_POL      = 8'h1C;
    localparam logic [ADDR_W-1:0] OFF_NMI      = 8'h24;
endpackage

// File: rtl/extint_sync.sv
// Two-flop synchroniser for a vector of asynchronous pins.
// Assumes each pin is independent; no cross-bit coherence is promised.
module extint_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Shift the raw pins through two registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/extint_line.sv
// Detector and status flag for one synchronised pin.
// Assumes sync_in is already in the clock domain. Edge status is sticky
// until cleared, and a same-cycle event beats the clear. Level status
// tracks the active condition.
module extint_line (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    input  logic lvl_mode,
    input  logic rise_sel,
    input  logic high_sel,
    input  logic clr,
    output logic status
);
    logic prev_q;
    logic rise_evt;
    logic fall_evt;
    logic edge_evt;
    logic lvl_active;

    // Remember the previous synchronised value for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_in;
    end

    // Decode the selected edge and the active level.
    always_comb begin
        rise_evt   = sync_in & ~prev_q;
        fall_evt   = ~sync_in & prev_q;
        edge_evt   = rise_sel ? rise_evt : fall_evt;
        lvl_active = high_sel ? sync_in : ~sync_in;
    end

    // Update the status flag according to the sense mode.
    always_ff @(posedge clk) begin
        if (!rst_n)        status <= 1'b0;
        else if (lvl_mode) status <= lvl_active;
        else               status <= (status & ~clr) | edge_evt;
    end
endmodule

// File: rtl/extint_ctrl.sv
// External interrupt controller top: register file, per-pin detectors,
// and the interrupt combiners. Assumes one write per bus_wen pulse and a
// combinational read; NUM_LINES must be between 1 and DATA_W.
module extint_ctrl
    import extint_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] ext_in,
    input  logic                 bus_wen,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 irq_out,
    output logic                 nmi_out
);
    localparam int N = NUM_LINES;

    logic [N-1:0] sync_pins;
    logic [N-1:0] mask_q;
    logic [N-1:0] sense_q;
    logic [N-1:0] dir_q;
    logic [N-1:0] pol_q;
    logic [N-1:0] status;
    logic [N-1:0] clr_vec;
    logic [N-1:0] wd_lines;
    logic         nmi_en_q;

    assign wd_lines = bus_wdata[N-1:0];

    extint_sync #(.W(N)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_in),
        .sync_out (sync_pins)
    );

    // Form the per-pin clear strobe from a write to the clear offset.
    always_comb begin
        clr_vec = (bus_wen && bus_addr == OFF_STAT_CLR) ? wd_lines : '0;
    end

    for (genvar i = 0; i < N; i++) begin : g_line
        extint_line u_line (
            .clk      (clk),
            .rst_n    (rst_n),
            .sync_in  (sync_pins[i]),
            .lvl_mode (sense_q[i]),
            .rise_sel (dir_q[i]),
            .high_sel (pol_q[i]),
            .clr      (clr_vec[i]),
            .status   (status[i])
        );
    end

    // Register writes: set/clear strobes for the mask, plain writes for config.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q   <= '0;
            sense_q  <= '0;
            dir_q    <= '0;
            pol_q    <= '0;
            nmi_en_q <= 1'b0;
        end else if (bus_wen) begin
            case (bus_addr)
                OFF_MASK_SET: mask_q   <= mask_q | wd_lines;
                OFF_MASK_CLR: mask_q   <= mask_q & ~wd_lines;
                OFF_SENSE:    sense_q  <= wd_lines;
                OFF_DIR:      dir_q    <= wd_lines;
                OFF_POL:      pol_q    <= wd_lines;
                OFF_NMI:      nmi_en_q <= bus_wdata[0];
                default:      ;
            endcase
        end
    end

    // Read mux with zero extension above the implemented pins.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_MASK_RD: bus_rdata[N-1:0] = mask_q;
            OFF_STATUS:  bus_rdata[N-1:0] = status;
            OFF_SENSE:   bus_rdata[N-1:0] = sense_q;
            OFF_DIR:     bus_rdata[N-1:0] = dir_q;
            OFF_POL:     bus_rdata[N-1:0] = pol_q;
            OFF_NMI:     bus_rdata[0]     = nmi_en_q;
            default:     bus_rdata = '0;
        endcase
    end

    // Combine pending, enabled pins and the non-maskable request.
    always_comb begin
        irq_out = |(status & mask_q);
        nmi_out = nmi_en_q & status[0];
    end
endmodule

// File: rtl/extint_ctrl_chk.sv
// Checker bound to extint_ctrl: watches mask strobes, sticky edge status
// and output gating. Assumes the package offsets used by the top.
module extint_ctrl_chk
    import extint_pkg::*;
#(
    parameter int N = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wen,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [N-1:0]      mask,
    input logic [N-1:0]      status,
    input logic [N-1:0]      sense,
    input logic              nmi_en,
    input logic              irq_out,
    input logic              nmi_out
);
    logic [N-1:0] wd;
    logic [N-1:0] clr_seen;
    logic         mask_wr;

    // Derive the strobe views of the bus in the checker.
    always_comb begin
        wd       = bus_wdata[N-1:0];
        clr_seen = (bus_wen && bus_addr == OFF_STAT_CLR) ? wd : '0;
        mask_wr  = bus_wen && (bus_addr == OFF_MASK_SET || bus_addr == OFF_MASK_CLR);
    end

    AST_MASK_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == OFF_MASK_SET) |=> ((mask & $past(wd)) == $past(wd))); // R2
    AST_MASK_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == OFF_MASK_CLR) |=> ((mask & $past(wd)) == '0)); // R2
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr |=> $stable(mask)); // R2
    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~status & $past(status) & ~$past(sense) & ~$past(clr_seen)) == '0)); // R4
    AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ((status & mask) != '0)); // R6
    AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & mask) != '0) |-> irq_out); // R6
    AST_NMI_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_out |-> (nmi_en && status[0])); // R7
endmodule

bind extint_ctrl extint_ctrl_chk #(.N(NUM_LINES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wen   (bus_wen),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .mask      (mask_q),
    .status    (status),
    .sense     (sense_q),
    .nmi_en    (nmi_en_q),
    .irq_out   (irq_out),
    .nmi_out   (nmi_out)
);

// File: tb/sim_extint_ctrl.sv
// Sweep bench for extint_ctrl with four pins: every pin against every
// trigger kind, plus strobe, readback and corner checks.
module sim_extint_ctrl;
    localparam int NL = 4;
    localparam logic [31:0] ALL = (32'd1 << NL) - 32'd1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] ext_in = '0;
    logic          bus_wen = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq_out;
    logic          nmi_out;

    int n_chk = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    extint_ctrl #(.NUM_LINES(NL)) u0 (
        .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .bus_wen(bus_wen),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out), .nmi_out(nmi_out)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wen = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic edges(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
    endtask

    // Program all pins with one trigger kind: 0 low, 1 high, 2 rise, 3 fall.
    task automatic setup_kind(input int t);
        wr(8'h14, (t < 2) ? ALL : 32'h0);
        wr(8'h18, (t == 2) ? ALL : 32'h0);
        wr(8'h1C, (t == 1) ? ALL : 32'h0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [NL-1:0] idle;
        edges(3);
        @(negedge clk) rst_n = 1'b1;

        // R1 / R9: reset values and write-only offsets read zero
        for (int a = 0; a <= 8'h24; a += 4) begin
            rd(a[7:0], v); chk("R1", v, 32'h0);
        end
        chk("R1", {30'b0, irq_out, nmi_out}, 32'h0);

        // R8: unimplemented bits do not stick
        wr(8'h14, 32'hFFFF_FFFF); rd(8'h14, v); chk("R8", v, ALL);
        wr(8'h18, 32'hFFFF_FFFF); rd(8'h18, v); chk("R8", v, ALL);
        wr(8'h1C, 32'hFFFF_FFFF); rd(8'h1C, v); chk("R8", v, ALL);
        wr(8'h00, 32'hFFFF_FFFF); rd(8'h08, v); chk("R8", v, ALL);
        wr(8'h04, ALL); wr(8'h14, 0); wr(8'h18, 0); wr(8'h1C, 0);

        // R2: set/clear strobes, zero bits ignored
        wr(8'h00, 32'h5); rd(8'h08, v); chk("R2", v, 32'h5);
        wr(8'h00, 32'h2); rd(8'h08, v); chk("R2", v, 32'h7);
        wr(8'h04, 32'h4); rd(8'h08, v); chk("R2", v, 32'h3);
        wr(8'h04, 32'h0); rd(8'h08, v); chk("R2", v, 32'h3);
        wr(8'h00, 32'h0); rd(8'h08, v); chk("R2", v, 32'h3);
        wr(8'h04, ALL);

        // R3 / R5 / R6 / R4: every pin against every trigger kind
        for (int t = 0; t < 4; t++) begin
            for (int l = 0; l < NL; l++) begin
                idle = (t == 0 || t == 3) ? '1 : '0;
                setup_kind(t);
                @(negedge clk) ext_in = idle;
                edges(4);
                wr(8'h10, ALL);
                wr(8'h00, ALL);
                rd(8'h0C, v); chk((t < 2) ? "R5" : "R3", v, 32'h0);
                chk("R6", {31'b0, irq_out}, 32'h0);
                @(negedge clk) ext_in = idle ^ NL'(1 << l);
                edges(2);
                rd(8'h0C, v); chk((t < 2) ? "R5" : "R3", v, 32'h0);
                edges(1);
                rd(8'h0C, v); chk((t < 2) ? "R5" : "R3", v, 32'(1 << l));
                chk("R6", {31'b0, irq_out}, 32'h1);
                if (t < 2) begin
                    wr(8'h10, ALL); edges(1);
                    rd(8'h0C, v); chk("R5", v, 32'(1 << l));
                end
                wr(8'h04, 32'(1 << l));
                chk("R6", {31'b0, irq_out}, 32'h0);
                wr(8'h00, 32'(1 << l));
                @(negedge clk) ext_in = idle;
                edges(4);
                rd(8'h0C, v);
                chk((t < 2) ? "R5" : "R3", v, (t < 2) ? 32'h0 : 32'(1 << l));
                if (t >= 2) begin
                    wr(8'h10, 32'h0); rd(8'h0C, v); chk("R4", v, 32'(1 << l));
                    wr(8'h10, 32'(1 << l)); rd(8'h0C, v); chk("R4", v, 32'h0);
                    chk("R6", {31'b0, irq_out}, 32'h0);
                end
                wr(8'h04, ALL);
            end
        end

        // R4: new rising edge in the cycle of a clear keeps the flag
        setup_kind(2);
        @(negedge clk) ext_in = '0;
        edges(4);
        wr(8'h10, ALL);
        @(negedge clk) ext_in = 4'b0010;
        edges(4);
        @(negedge clk) ext_in = 4'b0000;
        edges(4);
        rd(8'h0C, v); chk("R4", v, 32'h2);
        @(negedge clk) ext_in = 4'b0010;
        edges(2);
        wr(8'h10, 32'h2);
        rd(8'h0C, v); chk("R4", v, 32'h2);
        wr(8'h10, 32'h2);
        rd(8'h0C, v); chk("R4", v, 32'h0);

        // R7: non-maskable path ignores the mask and follows pin 0 only
        setup_kind(1);
        @(negedge clk) ext_in = '0;
        edges(4);
        wr(8'h24, 32'h1); rd(8'h24, v); chk("R7", v, 32'h1);
        @(negedge clk) ext_in = 4'b0010;
        edges(4);
        chk("R7", {31'b0, nmi_out}, 32'h0);
        @(negedge clk) ext_in = 4'b0001;
        edges(3);
        @(negedge clk);
        chk("R7", {30'b0, nmi_out, irq_out}, 32'h2);
        wr(8'h24, 32'h0);
        chk("R7", {31'b0, nmi_out}, 32'h0);
        @(negedge clk) ext_in = '0;

        // R10: all level mode, edge and level cleared -> low-level trigger
        wr(8'h14, ALL); wr(8'h18, 0); wr(8'h1C, 0);
        @(negedge clk) ext_in = '1;
        edges(4);
        rd(8'h0C, v); chk("R10", v, 32'h0);
        @(negedge clk) ext_in = 4'b0101;
        edges(3);
        rd(8'h0C, v); chk("R10", v, 32'hA);
        @(negedge clk) ext_in = '0;
        edges(3);
        rd(8'h0C, v); chk("R10", v, ALL);

        // R9: undefined offsets read zero and writes there change nothing
        wr(8'h00, 32'h9);
        wr(8'h20, 32'hFFFF_FFFF); wr(8'h28, 32'hFFFF_FFFF); wr(8'h3C, 32'hFFFF_FFFF);
        rd(8'h20, v); chk("R9", v, 32'h0);
        rd(8'h3C, v); chk("R9", v, 32'h0);
        rd(8'h08, v); chk("R9", v, 32'h9);
        rd(8'h14, v); chk("R9", v, ALL);
        rd(8'h24, v); chk("R9", v, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule